// File: doc/BRIEF.md
# Three-Wire Configuration Register Bank

This block is a serial slave that configures a down-converter front end. Software, or a host controller, shifts 18-bit words in over three wires: a data line, a bit clock and a latch strobe. The two leading bits of each word are an address. The remaining 16 bits carry fields whose placement depends on that address. A rising latch strobe moves the captured word into the addressed register group. The register groups hold the divider counts of a frequency synthesiser (main, swallow and reference counts), a reference-clock output enable, a test-routing enable, test input and output routing codes, and a filter select. All fields leave the block as plain decoded outputs.

The block runs on a fast system clock. The three bus pins and the enable pin are asynchronous to that clock, so the block synchronises them and detects their edges internally. When enable goes low, the whole bank returns to its reset values and ignores the bus. When enable rises after a long enough low period, the levels on the three bus pins act as configuration straps and can load one of two preset synthesiser setups without any serial write. Power-on counts as such a qualifying low period.

The controlling state machine has six states. OFF holds the bank cleared while enable is low. PRESET lasts one cycle and applies the strapped setup. IDLE waits for the first bit of a word. SHIFT collects bits. COMMIT lasts one cycle and writes a well-formed word. REJECT lasts one cycle and discards a malformed word. The transitions are as follows:
- Any state goes to OFF when enable is low.
- OFF goes to PRESET when enable rises after a qualifying low, and to IDLE when the low was too short.
- PRESET goes to IDLE.
- IDLE goes to SHIFT on a bit-clock rise, and to REJECT on a latch rise.
- SHIFT goes to COMMIT on a latch rise after exactly 18 bits, and to REJECT on a latch rise after any other count.
- COMMIT and REJECT go back to IDLE.

Top module: `cfg_bank`

## Requirements
- R1: Each word is shifted in most significant bit first, one bit per rising bit-clock edge. Word bits 17:16 form the address and bits 15:0 the data. A rising latch edge after exactly 18 bits writes the word into the addressed register group.
- R2: Address 0 writes the main count from data bits 15:5 and the clock-output enable from data bit 1. Data bits 4:2 and 0 are ignored.
- R3: Address 1 writes the swallow count from data bits 15:11, the reference count from data bits 10:2 and the test-routing enable from data bit 0. Data bit 1 is ignored.
- R4: Address 2 writes the test input code from data bits 15:13, the test output code from data bits 12:10 and the filter select from data bit 1. All other data bits are ignored.
- R5: Address 3 writes the same fields, from the same bit positions, as address 0.
- R6: A test input or test output code of 3 or 4 is stored as 0, which means normal operation. The other codes (0, 1, 2, 5, 6, 7) are stored as written. Neither routing output ever shows 3 or 4.
- R7: A latch rise after a bit count other than 18, including zero, discards the word and sets frame_error. frame_error stays set until enable goes low. Well-formed words still commit while it is set.
- R8: While enable is low, every field output and frame_error is 0, and serial words are ignored.
- R9: Enable rises after a qualifying low, or at power-on, with straps (data, clock, latch) = (1,0,0). This loads main count 7, swallow count 3 and reference count 4, and every other field 0. That gives divide ratio 24*7+3 = 171 on a doubled 18.414 MHz reference divided by 4, for 1574.397 MHz.
- R10: The same rise with straps (1,1,0) loads main count 22, swallow count 17 and reference count 9, and every other field 0. That gives ratio 545 on a doubled 13 MHz reference divided by 9, for 1574.444 MHz.
- R11: The same rise with any other strap pattern, including the reserved (0,0,0), leaves all fields at 0.
- R12: If enable was low for fewer than LOW_MIN_CYCLES system clocks before rising, no preset is loaded and all fields stay 0.
- R13: Field outputs change only after a COMMIT, a PRESET or the OFF state. Bits shifted in without a latch leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Active-high enable; low clears the bank |
| ser_data | input | 1 | Serial data, also the first strap |
| ser_clk | input | 1 | Serial bit clock, also the second strap |
| ser_latch | input | 1 | Latch strobe, also the third strap |
| main_div | output | 11 | Main count |
| swal_div | output | 5 | Swallow count |
| ref_div | output | 9 | Reference count |
| clk_out_en | output | 1 | Reference-clock output enable |
| test_en | output | 1 | Test-routing enable |
| test_in_sel | output | 3 | Test input routing code |
| test_out_sel | output | 3 | Test output routing code |
| filt_sel | output | 1 | Filter select |
| frame_error | output | 1 | Sticky malformed-word flag |

## Verification
The assertions assume that the bus pins move slowly compared with the system clock. Each level must stay put for several clocks, so that the synchroniser delivers every edge. They also assume that a latch rise never lands in the same cycle as a bit-clock rise, and that the straps stay steady for some cycles after enable rises. The stimulus keeps to this by holding every data, clock-high and clock-low phase for 8 system cycles and the latch high for 16. It also keeps the strap levels for 12 cycles after enable goes high. Low periods are chosen well below or well above LOW_MIN_CYCLES so that the preset decision is never borderline.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;

    // word geometry
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;
    localparam int WORD_W = ADDR_W + DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    // field widths
    localparam int MAIN_W = 11;
    localparam int SWAL_W = 5;
    localparam int REF_W  = 9;
    localparam int SEL_W  = 3;
    localparam int STRAP_W = 3;

    // field positions inside the data part
    localparam int MAIN_LSB = DATA_W - MAIN_W;
    localparam int CKEN_BIT = 1;
    localparam int SWAL_LSB = DATA_W - SWAL_W;
    localparam int REF_LSB  = SWAL_LSB - REF_W;
    localparam int TEN_BIT  = 0;
    localparam int TI_LSB   = DATA_W - SEL_W;
    localparam int TO_LSB   = TI_LSB - SEL_W;
    localparam int FIL_BIT  = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MAIN     = 2'b00,
        ADDR_DIVS     = 2'b01,
        ADDR_TEST     = 2'b10,
        ADDR_MAIN_ALT = 2'b11
    } addr_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PRESET,
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_REJECT
    } ctrl_state_t;

    typedef struct packed {
        logic [MAIN_W-1:0] main_div;
        logic [SWAL_W-1:0] swal_div;
        logic [REF_W-1:0]  ref_div;
        logic              clk_out_en;
        logic              test_en;
        logic [SEL_W-1:0]  ti_sel;
        logic [SEL_W-1:0]  to_sel;
        logic              filt_sel;
    } cfg_fields_t;

    // strap order: {data, clock, latch}
    localparam logic [STRAP_W-1:0] STRAP_REF18 = 3'b100;
    localparam logic [STRAP_W-1:0] STRAP_REF13 = 3'b110;

    // 18.414 MHz doubled / 4 = 9.207 MHz compare; 171 = 24*7 + 3
    localparam int P18_MAIN = 7;
    localparam int P18_SWAL = 3;
    localparam int P18_REF  = 4;
    // 13 MHz doubled / 9 = 2.889 MHz compare; 545 = 24*22 + 17
    localparam int P13_MAIN = 22;
    localparam int P13_SWAL = 17;
    localparam int P13_REF  = 9;

    function automatic cfg_fields_t preset_for(input logic [STRAP_W-1:0] strap);
        cfg_fields_t f;
        f = '0;
        case (strap)
            STRAP_REF18: begin
                f.main_div = MAIN_W'(P18_MAIN);
                f.swal_div = SWAL_W'(P18_SWAL);
                f.ref_div  = REF_W'(P18_REF);
            end
            STRAP_REF13: begin
                f.main_div = MAIN_W'(P13_MAIN);
                f.swal_div = SWAL_W'(P13_SWAL);
                f.ref_div  = REF_W'(P13_REF);
            end
            default: f = '0;
        endcase
        return f;
    endfunction

    // unused routing codes fall back to normal operation
    function automatic logic [SEL_W-1:0] fold_sel(input logic [SEL_W-1:0] code);
        if (code == SEL_W'(3) || code == SEL_W'(4)) begin
            return '0;
        end
        return code;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int CHAIN_W = STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= d;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[CHAIN_W-WIDTH-1:0], d};
                end
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/cfg_shift.sv
`timescale 1ns/1ps
module cfg_shift
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              cnt_clear,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              frame_full
);

    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WORD_W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cnt_clear) begin
            bit_cnt <= '0;
        end else if (shift_en && bit_cnt != '1) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    assign frame_full = (bit_cnt == CNT_W'(WORD_W));

endmodule

// File: rtl/cfg_ctrl.sv
`timescale 1ns/1ps
module cfg_ctrl
    import cfg_pkg::*;
#(
    parameter int LOW_MIN_CYCLES = 1_250_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_s,
    input  logic        sclk_s,
    input  logic        latch_s,
    input  logic        frame_full,
    output ctrl_state_t state,
    output logic        shift_en,
    output logic        cnt_clear,
    output logic        clear_all,
    output logic        load_preset,
    output logic        commit,
    output logic        reject
);

    localparam int TMR_W = $clog2(LOW_MIN_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_DONE = TMR_W'(LOW_MIN_CYCLES);

    ctrl_state_t      state_nx;
    logic [TMR_W-1:0] low_tmr;
    logic             low_ok;
    logic             sclk_q;
    logic             latch_q;
    logic             clk_rise;
    logic             latch_rise;

    // edge detection on synchronised bus pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            sclk_q  <= sclk_s;
            latch_q <= latch_s;
        end
    end

    assign clk_rise   = sclk_s & ~sclk_q;
    assign latch_rise = latch_s & ~latch_q;

    // low-period timer; starts qualified so power-on acts as a long low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_tmr <= TMR_DONE;
        end else if (en_s) begin
            low_tmr <= '0;
        end else if (low_tmr != TMR_DONE) begin
            low_tmr <= low_tmr + TMR_W'(1);
        end
    end

    assign low_ok = (low_tmr == TMR_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!en_s) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    state_nx = low_ok ? ST_PRESET : ST_IDLE;
                ST_PRESET: state_nx = ST_IDLE;
                ST_IDLE: begin
                    if (latch_rise) begin
                        state_nx = ST_REJECT;
                    end else if (clk_rise) begin
                        state_nx = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (latch_rise) begin
                        state_nx = frame_full ? ST_COMMIT : ST_REJECT;
                    end
                end
                ST_COMMIT: state_nx = ST_IDLE;
                ST_REJECT: state_nx = ST_IDLE;
                default:   state_nx = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_en    = 1'b0;
        cnt_clear   = 1'b0;
        clear_all   = 1'b0;
        load_preset = 1'b0;
        commit      = 1'b0;
        reject      = 1'b0;
        unique case (state)
            ST_OFF: begin
                clear_all = 1'b1;
                cnt_clear = 1'b1;
            end
            ST_PRESET: load_preset = 1'b1;
            ST_IDLE, ST_SHIFT: shift_en = clk_rise & ~latch_rise & en_s;
            ST_COMMIT: begin
                commit    = 1'b1;
                cnt_clear = 1'b1;
            end
            ST_REJECT: begin
                reject    = 1'b1;
                cnt_clear = 1'b1;
            end
            default: clear_all = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
module cfg_regs
    import cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_all,
    input  logic               load_preset,
    input  logic [STRAP_W-1:0] strap,
    input  logic               commit,
    input  logic               reject,
    input  logic [WORD_W-1:0]  word,
    output cfg_fields_t        fields,
    output logic               frame_error
);

    cfg_fields_t          nxt;
    logic [ADDR_W-1:0]    addr;
    logic [DATA_W-1:0]    data;

    assign addr = word[WORD_W-1 -: ADDR_W];
    assign data = word[DATA_W-1:0];

    always_comb begin
        nxt = fields;
        if (commit) begin
            unique case (addr_t'(addr))
                ADDR_MAIN, ADDR_MAIN_ALT: begin
                    nxt.main_div   = data[MAIN_LSB +: MAIN_W];
                    nxt.clk_out_en = data[CKEN_BIT];
                end
                ADDR_DIVS: begin
                    nxt.swal_div = data[SWAL_LSB +: SWAL_W];
                    nxt.ref_div  = data[REF_LSB +: REF_W];
                    nxt.test_en  = data[TEN_BIT];
                end
                ADDR_TEST: begin
                    nxt.ti_sel   = fold_sel(data[TI_LSB +: SEL_W]);
                    nxt.to_sel   = fold_sel(data[TO_LSB +: SEL_W]);
                    nxt.filt_sel = data[FIL_BIT];
                end
                default: nxt = fields;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields <= '0;
        end else if (clear_all) begin
            fields <= '0;
        end else if (load_preset) begin
            fields <= preset_for(strap);
        end else begin
            fields <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_error <= 1'b0;
        end else if (clear_all) begin
            frame_error <= 1'b0;
        end else if (reject) begin
            frame_error <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_bank.sv
`timescale 1ns/1ps
module cfg_bank
    import cfg_pkg::*;
#(
    parameter int LOW_MIN_CYCLES = 1_250_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_latch,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swal_div,
    output logic [REF_W-1:0]  ref_div,
    output logic              clk_out_en,
    output logic              test_en,
    output logic [SEL_W-1:0]  test_in_sel,
    output logic [SEL_W-1:0]  test_out_sel,
    output logic              filt_sel,
    output logic              frame_error
);

    localparam int PIN_W = 4;

    logic [PIN_W-1:0]  pins_s;
    logic              en_s;
    logic              latch_s;
    logic              sclk_s;
    logic              data_s;
    ctrl_state_t       ctrl_state;
    logic              shift_en;
    logic              cnt_clear;
    logic              clear_all;
    logic              load_preset;
    logic              commit;
    logic              reject;
    logic              frame_full;
    logic [WORD_W-1:0] word;
    cfg_fields_t       fields;

    cfg_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({enable, ser_latch, ser_clk, ser_data}),
        .q     (pins_s)
    );

    assign {en_s, latch_s, sclk_s, data_s} = pins_s;

    cfg_ctrl #(
        .LOW_MIN_CYCLES (LOW_MIN_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_s        (en_s),
        .sclk_s      (sclk_s),
        .latch_s     (latch_s),
        .frame_full  (frame_full),
        .state       (ctrl_state),
        .shift_en    (shift_en),
        .cnt_clear   (cnt_clear),
        .clear_all   (clear_all),
        .load_preset (load_preset),
        .commit      (commit),
        .reject      (reject)
    );

    cfg_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .cnt_clear  (cnt_clear),
        .din        (data_s),
        .word       (word),
        .frame_full (frame_full)
    );

    cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_all   (clear_all),
        .load_preset (load_preset),
        .strap       ({data_s, sclk_s, latch_s}),
        .commit      (commit),
        .reject      (reject),
        .word        (word),
        .fields      (fields),
        .frame_error (frame_error)
    );

    assign main_div     = fields.main_div;
    assign swal_div     = fields.swal_div;
    assign ref_div      = fields.ref_div;
    assign clk_out_en   = fields.clk_out_en;
    assign test_en      = fields.test_en;
    assign test_in_sel  = fields.ti_sel;
    assign test_out_sel = fields.to_sel;
    assign filt_sel     = fields.filt_sel;

endmodule

// File: rtl/cfg_bank_chk.sv
`timescale 1ns/1ps
module cfg_bank_chk
    import cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input ctrl_state_t       state,
    input logic [MAIN_W-1:0] main_div,
    input logic [SWAL_W-1:0] swal_div,
    input logic [REF_W-1:0]  ref_div,
    input logic              clk_out_en,
    input logic              test_en,
    input logic [SEL_W-1:0]  test_in_sel,
    input logic [SEL_W-1:0]  test_out_sel,
    input logic              filt_sel,
    input logic              frame_error
);

    // R8
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (main_div == '0 && swal_div == '0 && ref_div == '0
            && !clk_out_en && !test_en && test_in_sel == '0 && test_out_sel == '0
            && !filt_sel && !frame_error));

    // R7
    reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT) |=> frame_error);

    // R7
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_error && state != ST_OFF) |=> frame_error);

    // R13
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT && state != ST_PRESET && state != ST_OFF)
            |=> $stable({main_div, swal_div, ref_div, clk_out_en, test_en,
                         test_in_sel, test_out_sel, filt_sel}));

    // R6
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_in_sel != SEL_W'(3) && test_in_sel != SEL_W'(4)
            && test_out_sel != SEL_W'(3) && test_out_sel != SEL_W'(4)));

endmodule

bind cfg_bank cfg_bank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (ctrl_state),
    .main_div     (main_div),
    .swal_div     (swal_div),
    .ref_div      (ref_div),
    .clk_out_en   (clk_out_en),
    .test_en      (test_en),
    .test_in_sel  (test_in_sel),
    .test_out_sel (test_out_sel),
    .filt_sel     (filt_sel),
    .frame_error  (frame_error)
);

// File: tb/tb_cfg_bank.sv
`timescale 1ns/1ps
module tb_cfg_bank;

    localparam int LOW_MIN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_latch = 1'b0;
    logic [10:0] main_div;
    logic [4:0]  swal_div;
    logic [8:0]  ref_div;
    logic        clk_out_en;
    logic        test_en;
    logic [2:0]  test_in_sel;
    logic [2:0]  test_out_sel;
    logic        filt_sel;
    logic        frame_error;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_bank #(.LOW_MIN_CYCLES(LOW_MIN), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch),
        .main_div(main_div), .swal_div(swal_div), .ref_div(ref_div),
        .clk_out_en(clk_out_en), .test_en(test_en),
        .test_in_sel(test_in_sel), .test_out_sel(test_out_sel),
        .filt_sel(filt_sel), .frame_error(frame_error)
    );

    typedef struct packed {
        logic [17:0] word;
        logic [10:0] mn;
        logic [4:0]  sc;
        logic [8:0]  rc;
        logic        ck;
        logic        te;
        logic [2:0]  ti;
        logic [2:0]  to;
        logic        fl;
    } vec_t;

    localparam int NVEC = 9;
    // each row: word written, then the whole field set expected afterwards
    localparam vec_t VECS [NVEC] = '{
        '{word:{2'b00, 11'h5A3, 5'b00010},      mn:11'h5A3, sc:5'h03, rc:9'h004, ck:1'b1, te:1'b0, ti:3'd0, to:3'd0, fl:1'b0},
        '{word:{2'b01, 5'h15, 9'h1AB, 2'b01},   mn:11'h5A3, sc:5'h15, rc:9'h1AB, ck:1'b1, te:1'b1, ti:3'd0, to:3'd0, fl:1'b0},
        '{word:{2'b10, 3'd5, 3'd7, 8'hFF, 2'b11}, mn:11'h5A3, sc:5'h15, rc:9'h1AB, ck:1'b1, te:1'b1, ti:3'd5, to:3'd7, fl:1'b1},
        '{word:{2'b11, 11'h00F, 5'b11101},      mn:11'h00F, sc:5'h15, rc:9'h1AB, ck:1'b0, te:1'b1, ti:3'd5, to:3'd7, fl:1'b1},
        '{word:{2'b10, 3'd3, 3'd4, 10'b0},      mn:11'h00F, sc:5'h15, rc:9'h1AB, ck:1'b0, te:1'b1, ti:3'd0, to:3'd0, fl:1'b0},
        '{word:{2'b10, 3'd4, 3'd3, 8'h00, 2'b10}, mn:11'h00F, sc:5'h15, rc:9'h1AB, ck:1'b0, te:1'b1, ti:3'd0, to:3'd0, fl:1'b1},
        '{word:{2'b10, 3'd6, 3'd1, 8'h00, 2'b10}, mn:11'h00F, sc:5'h15, rc:9'h1AB, ck:1'b0, te:1'b1, ti:3'd6, to:3'd1, fl:1'b1},
        '{word:{2'b01, 5'h1F, 9'h1FF, 2'b11},   mn:11'h00F, sc:5'h1F, rc:9'h1FF, ck:1'b0, te:1'b1, ti:3'd6, to:3'd1, fl:1'b1},
        '{word:{2'b00, 11'h7FF, 5'b00010},      mn:11'h7FF, sc:5'h1F, rc:9'h1FF, ck:1'b1, te:1'b1, ti:3'd6, to:3'd1, fl:1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            tick(8);
            ser_clk = 1'b1;
            tick(8);
            ser_clk = 1'b0;
        end
        tick(8);
        ser_data = 1'b0;
    endtask

    task automatic pulse_latch();
        tick(8);
        ser_latch = 1'b1;
        tick(16);
        ser_latch = 1'b0;
        tick(12);
    endtask

    task automatic write_word(input logic [17:0] w);
        send_bits({14'b0, w}, 18);
        pulse_latch();
    endtask

    task automatic check(input string req, input vec_t e, input logic fe);
        logic [34:0] act;
        logic [34:0] exp_v;
        act   = {main_div, swal_div, ref_div, clk_out_en, test_en,
                 test_in_sel, test_out_sel, filt_sel, frame_error};
        exp_v = {e.mn, e.sc, e.rc, e.ck, e.te, e.ti, e.to, e.fl, fe};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    function automatic vec_t fv(input logic [10:0] mn, input logic [4:0] sc,
                                input logic [8:0] rc, input logic ck, input logic te,
                                input logic [2:0] ti, input logic [2:0] to, input logic fl);
        vec_t v;
        v = '{word:18'b0, mn:mn, sc:sc, rc:rc, ck:ck, te:te, ti:ti, to:to, fl:fl};
        return v;
    endfunction

    // drive straps during a low period, raise enable, release straps
    task automatic enable_with(input logic [2:0] strap, input int low_cycles);
        enable = 1'b0;
        {ser_data, ser_clk, ser_latch} = 3'b000;
        tick(low_cycles);
        {ser_data, ser_clk, ser_latch} = strap;
        tick(4);
        enable = 1'b1;
        tick(12);
        {ser_data, ser_clk, ser_latch} = 3'b000;
        tick(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t cur;
        tick(5);
        rst_n = 1'b1;
        tick(6);
        // R8: enable low after reset
        check("R8 reset", fv(0, 0, 0, 0, 0, 0, 0, 0), 1'b0);

        // R9: power-on counts as a qualifying low
        enable_with(3'b100, 4);
        check("R9 preset 18.414", fv(11'd7, 5'd3, 9'd4, 0, 0, 0, 0, 0), 1'b0);

        // R1 R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            write_word(VECS[i].word);
            check($sformatf("R1-walk row %0d (R2 R3 R4 R5 R6)", i), VECS[i], 1'b0);
        end
        cur = VECS[NVEC-1];

        // R7: 17-bit word discarded
        send_bits({15'b0, 17'h0ABCD}, 17);
        pulse_latch();
        check("R7 short word", cur, 1'b1);

        // R7 R1: good word still commits while error is set
        write_word({2'b10, 3'd2, 3'd5, 10'b0});
        cur.ti = 3'd2; cur.to = 3'd5; cur.fl = 1'b0;
        check("R7 commit with sticky error", cur, 1'b1);

        // R13: bits without latch change nothing
        send_bits({22'b0, 10'h3FF}, 10);
        check("R13 partial word", cur, 1'b1);
        pulse_latch();
        check("R7 partial latched", cur, 1'b1);

        // R7: 19-bit word discarded
        send_bits({13'b0, 1'b1, 18'b0}, 19);
        pulse_latch();
        check("R7 long word", cur, 1'b1);

        // R7: latch with zero bits
        pulse_latch();
        check("R7 bare latch", cur, 1'b1);

        // R8: enable low clears and ignores writes
        enable = 1'b0;
        tick(10);
        check("R8 enable low clears", fv(0, 0, 0, 0, 0, 0, 0, 0), 1'b0);
        write_word({2'b00, 11'h155, 5'b00010});
        check("R8 write while low", fv(0, 0, 0, 0, 0, 0, 0, 0), 1'b0);
        enable = 1'b1;
        tick(10);

        // R12: short low period loads no preset
        enable_with(3'b110, 20);
        check("R12 short low", fv(0, 0, 0, 0, 0, 0, 0, 0), 1'b0);

        // R10: long low with (1,1,0)
        enable_with(3'b110, 120);
        check("R10 preset 13", fv(11'd22, 5'd17, 9'd9, 0, 0, 0, 0, 0), 1'b0);

        // R11: reserved and other straps
        enable_with(3'b000, 120);
        check("R11 reserved strap", fv(0, 0, 0, 0, 0, 0, 0, 0), 1'b0);
        enable_with(3'b010, 120);
        check("R11 other strap", fv(0, 0, 0, 0, 0, 0, 0, 0), 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule